// File: doc/BRIEF.md
# Register-List Stack Frame Sequencer

This block creates and removes a subroutine stack frame on behalf of a processor pipeline. It keeps a 32-bit stack pointer. A push-frame command saves any subset of the twelve registers r20 to r31, chosen by a 12-bit mask, into memory below the stack pointer. It then lowers the pointer further to reserve room for locals. A pop-frame command does the reverse. It first releases the local room, then reloads the selected registers from memory. It can finally hand back the contents of a named register as the next program address.

Memory traffic uses a single word-wide request/acknowledge port, and each access is held until the acknowledge arrives. Register values come from, and go back to, the register file through one read port and one registered write port. Only entries that are set in the mask use a memory cycle. A one-cycle done strobe marks the end of every command. A command offered while one is in progress is dropped.

Top module: `frame_seq`

## Requirements
- R1: After reset the stack pointer equals the parameter SP_RESET (default 0x200), busy is low, no memory request is raised and done is low.
- R2: A push-frame command (cmd_op = 0) visits mask bits from bit 0 upward. For each set bit i it writes register r(20+i) as one word at the current stack pointer minus 4, and the pointer then drops by 4. A lower-numbered register therefore lands at a higher address.
- R3: Once the push-frame stores are finished, the stack pointer drops by 4 times cmd_imm.
- R4: A pop-frame command (cmd_op = 1) first raises the stack pointer by 4 times cmd_imm. It then visits mask bits from bit 11 downward. For each set bit i it reads the word at the stack pointer into r(20+i), and the pointer then rises by 4.
- R5: Each command makes exactly as many memory accesses as there are set mask bits. Clear bits cost no cycles. With an acknowledge that arrives L cycles after the request, done is high in cycle n·(L+1)+2 after the accept edge, counting the cycle right after that edge as cycle 1. An empty mask therefore finishes in cycle 2.
- R6: While a request waits for its acknowledge, the address, write flag and write data stay unchanged.
- R7: done is high for exactly one cycle per command and busy stays high from accept until done. A cmd_valid seen while busy is ignored and causes no extra memory access and no stack pointer change.
- R8: jump_valid rises together with done only for a pop-frame whose cmd_jreg is nonzero. In that case jump_addr is the value held in register cmd_jreg after all reloads.
- R9: Mask bit i maps to register index 20+i on both register-file ports. A reload reaches the write port one cycle after its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered (taken only when idle) |
| cmd_op | input | 1 | 0 push-frame, 1 pop-frame |
| cmd_list | input | 12 | Register selection mask, bit i is r(20+i) |
| cmd_imm | input | 5 | Local area size in words |
| cmd_jreg | input | 5 | Register holding return address for pop-frame, 0 for none |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| rf_rd_idx | output | 5 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_idx | output | 5 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| sp_out | output | 32 | Current stack pointer |
| done | output | 1 | Command finished (one cycle) |
| jump_valid | output | 1 | jump_addr is valid |
| jump_addr | output | 32 | Next program address from pop-frame |

## Verification
Every command is given at a falling edge and runs one edge later. Outputs are read only at falling edges. The bench counts falling edges until done and compares the count with n·(L+1)+2 for the memory latency it has set. The reload write strobe is registered, so the bench's register-file model takes the write at the falling edge after each read acknowledge, which puts the last reload in place before the cycle in which done and the jump address are read. The final stack pointer, the logged access order and the count of done pulses are checked after each command.

// File: rtl/frame_pkg.sv
package frame_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_FIN  = 2'd2
   } frame_state_t;

   typedef enum logic {
      OP_PUSH = 1'b0,
      OP_POP  = 1'b1
   } frame_op_t;
endpackage

// File: rtl/frame_pick.sv
module frame_pick #(
   parameter int N          = 12,
   parameter int IW         = 4,
   parameter bit HIGH_FIRST = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  mask,
   output logic          found,
   output logic [IW-1:0] idx
);
   generate
      if (N < 1 || (1 << IW) < N) begin : g_bad
         $error("frame_pick: index width too small for N");
      end
   endgenerate

   assign found = |mask;

   generate
      if (HIGH_FIRST) begin : g_high
         // last set bit seen wins, scanning upward, so the highest is chosen
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++)
               if (mask[i]) idx = IW'(i);
         end
      end else begin : g_low
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--)
               if (mask[i]) idx = IW'(i);
         end
      end
   endgenerate

   p_pick_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> mask[idx]);
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
   import frame_pkg::*;
#(
   parameter int NREGS  = 12,
   parameter int IMM_W  = 5,
   parameter int RIDX_W = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cmd_valid,
   input  logic                     cmd_op,
   input  logic [NREGS-1:0]         cmd_list,
   input  logic [IMM_W-1:0]         cmd_imm,
   input  logic [RIDX_W-1:0]        cmd_jreg,
   input  logic                     xfer_ack,
   output logic                     busy,
   output logic                     accept,
   output logic                     xfer_req,
   output logic [$clog2(NREGS)-1:0] cur_idx,
   output logic                     op_pop,
   output logic [IMM_W-1:0]         imm_q,
   output logic [RIDX_W-1:0]        jreg_q,
   output logic                     fin,
   output logic                     fin_enter
);
   localparam int LIW = $clog2(NREGS);

   frame_state_t     state_q, state_d;
   logic [NREGS-1:0] mask_q;
   logic             lo_found, hi_found;
   logic [LIW-1:0]   lo_idx, hi_idx;

   frame_pick #(.N(NREGS), .IW(LIW), .HIGH_FIRST(1'b0)) i_pick_lo (
      .clk(clk), .rst_n(rst_n), .mask(mask_q), .found(lo_found), .idx(lo_idx));
   frame_pick #(.N(NREGS), .IW(LIW), .HIGH_FIRST(1'b1)) i_pick_hi (
      .clk(clk), .rst_n(rst_n), .mask(mask_q), .found(hi_found), .idx(hi_idx));

   assign accept    = (state_q == ST_IDLE) && cmd_valid;
   assign busy      = (state_q != ST_IDLE);
   assign cur_idx   = op_pop ? hi_idx : lo_idx;
   assign xfer_req  = (state_q == ST_XFER) && (op_pop ? hi_found : lo_found);
   assign fin_enter = (state_q == ST_XFER) && !(op_pop ? hi_found : lo_found);
   assign fin       = (state_q == ST_FIN);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (accept)    state_d = ST_XFER;
         ST_XFER: if (fin_enter) state_d = ST_FIN;
         ST_FIN:                 state_d = ST_IDLE;
         default:                state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mask_q  <= '0;
         op_pop  <= 1'b0;
         imm_q   <= '0;
         jreg_q  <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            mask_q <= cmd_list;
            op_pop <= (frame_op_t'(cmd_op) == OP_POP);
            imm_q  <= cmd_imm;
            jreg_q <= cmd_jreg;
         end else if (xfer_req && xfer_ack) begin
            mask_q <= mask_q & ~(NREGS'(1) << cur_idx);
         end
      end
   end

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !fin);
   p_mask_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && xfer_ack) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));
   p_busy_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fin_enter && !(xfer_req && xfer_ack)) |=> $stable(mask_q) && $stable(imm_q));
endmodule

// File: rtl/frame_sp.sv
module frame_sp #(
   parameter int          XLEN     = 32,
   parameter int          IMM_W    = 5,
   parameter logic [31:0] SP_RESET = 32'h0000_0200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pre_add,
   input  logic             post_sub,
   input  logic             step_up,
   input  logic             step_dn,
   input  logic [IMM_W-1:0] imm,
   output logic [XLEN-1:0]  sp
);
   localparam int            WBYTES = XLEN / 8;
   localparam logic [XLEN-1:0] WSTEP = XLEN'(WBYTES);

   logic [XLEN-1:0] frame_bytes;
   assign frame_bytes = XLEN'(imm) * WSTEP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sp <= XLEN'(SP_RESET);
      else if (pre_add)  sp <= sp + frame_bytes;
      else if (post_sub) sp <= sp - frame_bytes;
      else if (step_up)  sp <= sp + WSTEP;
      else if (step_dn)  sp <= sp - WSTEP;
   end

   p_one_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pre_add, post_sub, step_up, step_dn}));
   p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step_up |=> (sp == $past(sp) + WSTEP));
   p_step_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step_dn |=> (sp == $past(sp) - WSTEP));
endmodule

// File: rtl/frame_seq.sv
module frame_seq #(
   parameter int          XLEN     = 32,
   parameter int          NREGS    = 12,
   parameter int          IMM_W    = 5,
   parameter int          RIDX_W   = 5,
   parameter int          REG_BASE = 20,
   parameter logic [31:0] SP_RESET = 32'h0000_0200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_op,
   input  logic [NREGS-1:0]  cmd_list,
   input  logic [IMM_W-1:0]  cmd_imm,
   input  logic [RIDX_W-1:0] cmd_jreg,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [XLEN-1:0]   mem_addr,
   output logic [XLEN-1:0]   mem_wdata,
   input  logic              mem_ack,
   input  logic [XLEN-1:0]   mem_rdata,
   output logic [RIDX_W-1:0] rf_rd_idx,
   input  logic [XLEN-1:0]   rf_rd_data,
   output logic              rf_we,
   output logic [RIDX_W-1:0] rf_wr_idx,
   output logic [XLEN-1:0]   rf_wr_data,
   output logic [XLEN-1:0]   sp_out,
   output logic              done,
   output logic              jump_valid,
   output logic [XLEN-1:0]   jump_addr
);
   localparam int            LIW   = $clog2(NREGS);
   localparam logic [XLEN-1:0] WSTEP = XLEN'(XLEN / 8);

   generate
      if (XLEN % 8 != 0 || XLEN < 16) begin : g_bad_xlen
         $error("frame_seq: XLEN must be a byte multiple of at least 16");
      end
      if (REG_BASE + NREGS > (1 << RIDX_W)) begin : g_bad_regs
         $error("frame_seq: register window exceeds register index range");
      end
   endgenerate

   logic             accept, xfer_req, op_pop, fin, fin_enter;
   logic [LIW-1:0]   cur_idx;
   logic [IMM_W-1:0] imm_q;
   logic [RIDX_W-1:0] jreg_q;
   logic [XLEN-1:0]  sp;
   logic [RIDX_W-1:0] cur_reg;
   logic             hit;

   frame_ctrl #(.NREGS(NREGS), .IMM_W(IMM_W), .RIDX_W(RIDX_W)) i_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_list(cmd_list),
      .cmd_imm(cmd_imm), .cmd_jreg(cmd_jreg), .xfer_ack(mem_ack),
      .busy(busy), .accept(accept), .xfer_req(xfer_req), .cur_idx(cur_idx),
      .op_pop(op_pop), .imm_q(imm_q), .jreg_q(jreg_q),
      .fin(fin), .fin_enter(fin_enter));

   assign hit = xfer_req && mem_ack;

   frame_sp #(.XLEN(XLEN), .IMM_W(IMM_W), .SP_RESET(SP_RESET)) i_sp (
      .clk(clk), .rst_n(rst_n),
      .pre_add(accept && (cmd_op == 1'b1)),
      .post_sub(fin_enter && !op_pop),
      .step_up(hit && op_pop),
      .step_dn(hit && !op_pop),
      .imm(accept ? cmd_imm : imm_q),
      .sp(sp));

   assign cur_reg   = RIDX_W'(REG_BASE) + RIDX_W'(cur_idx);
   assign sp_out    = sp;
   assign mem_req   = xfer_req;
   assign mem_we    = !op_pop;
   assign mem_addr  = op_pop ? sp : sp - WSTEP;
   assign mem_wdata = rf_rd_data;
   assign rf_rd_idx = fin ? jreg_q : cur_reg;

   assign done       = fin;
   assign jump_valid = fin && op_pop && (jreg_q != '0);
   assign jump_addr  = jump_valid ? rf_rd_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rf_we      <= 1'b0;
         rf_wr_idx  <= '0;
         rf_wr_data <= '0;
      end else begin
         rf_we <= hit && op_pop;
         if (hit && op_pop) begin
            rf_wr_idx  <= cur_reg;
            rf_wr_data <= mem_rdata;
         end
      end
   end

   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);
   p_load_writes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && !mem_we) |=> rf_we && (rf_wr_data == $past(mem_rdata)));
   p_jump_pop_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (jump_valid |-> done) and (!op_pop |-> !jump_valid));
endmodule

// File: tb/test_frame_seq.sv
module test_frame_seq;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] SPR = 32'h0000_0200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0, cmd_op = 1'b0;
   logic [11:0] cmd_list = '0;
   logic [4:0]  cmd_imm = '0, cmd_jreg = '0;
   logic        busy, mem_req, mem_we, mem_ack = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic [4:0]  rf_rd_idx, rf_wr_idx;
   logic [31:0] rf_rd_data, rf_wr_data, sp_out, jump_addr;
   logic        rf_we, done, jump_valid;

   logic [31:0] mem [0:255];
   logic [31:0] rf  [0:31];
   int          lat = 0, cnt = 0, log_n = 0, hold_err = 0, stray_jv = 0;
   logic [31:0] log_addr [0:31];
   logic [31:0] log_data [0:31];
   logic        log_we   [0:31];
   logic        pend = 1'b0;
   logic [31:0] pend_addr = '0;
   int          checks = 0, fails = 0;
   logic [31:0] exp_sp = SPR;

   always #(CLK_PERIOD / 2) clk = ~clk;
   assign rf_rd_data = rf[rf_rd_idx];

   frame_seq i_frame_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_list(cmd_list), .cmd_imm(cmd_imm), .cmd_jreg(cmd_jreg), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rf_rd_idx(rf_rd_idx),
      .rf_rd_data(rf_rd_data), .rf_we(rf_we), .rf_wr_idx(rf_wr_idx),
      .rf_wr_data(rf_wr_data), .sp_out(sp_out), .done(done),
      .jump_valid(jump_valid), .jump_addr(jump_addr));

   // memory responder and register-file model, acting on falling edges only
   always @(negedge clk) begin
      if (rf_we) rf[rf_wr_idx] = rf_wr_data;
      mem_ack = 1'b0;
      if (mem_req) begin
         if (pend && mem_addr != pend_addr) hold_err++;
         if (cnt == lat) begin
            mem_ack = 1'b1;
            mem_rdata = mem[mem_addr[9:2]];
            if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
            if (log_n < 32) begin
               log_addr[log_n] = mem_addr;
               log_data[log_n] = mem_we ? mem_wdata : mem[mem_addr[9:2]];
               log_we[log_n]   = mem_we;
            end
            log_n++;
            cnt = 0;
            pend = 1'b0;
         end else begin
            cnt++;
            pend = 1'b1;
            pend_addr = mem_addr;
         end
      end else begin
         pend = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // issue one command; spam>0 keeps offering a conflicting command while busy
   task automatic run_cmd(input logic op, input logic [11:0] list, input logic [4:0] imm,
                          input logic [4:0] jreg, input int spam,
                          output int cyc, output int ndone, output logic jv,
                          output logic [31:0] ja);
      int first;
      @(negedge clk);
      log_n = 0;
      cmd_valid = 1'b1; cmd_op = op; cmd_list = list; cmd_imm = imm; cmd_jreg = jreg;
      first = 0; ndone = 0; jv = 1'b0; ja = '0;
      for (int t = 0; t < 400; t++) begin
         @(negedge clk);
         if (t == 0) begin
            if (spam == 0) cmd_valid = 1'b0;
            else begin cmd_op = 1'b1; cmd_list = 12'hFFF; cmd_imm = 5'd9; end
         end
         if (spam != 0 && t == spam) cmd_valid = 1'b0;
         if (done) begin
            ndone++;
            if (first == 0) first = t + 1;
            if (jump_valid) begin jv = 1'b1; ja = jump_addr; end
         end else if (jump_valid) stray_jv++;
         if (first != 0 && t + 1 >= first + 3) break;
      end
      cyc = first;
   endtask

   task automatic t_reset();
      chk(sp_out == SPR, "R1", "reset sp", sp_out, SPR);
      chk(!busy, "R1", "reset busy", 32'(busy), 0);
      chk(!mem_req, "R1", "reset req", 32'(mem_req), 0);
      chk(!done, "R1", "reset done", 32'(done), 0);
   endtask

   task automatic push_check(input logic [11:0] list, input logic [4:0] imm,
                             input logic [4:0] jreg, input int spam);
      int cyc, nd, k, n;
      logic jv;
      logic [31:0] ja, s;
      n = $countones(list);
      s = exp_sp; k = 0;
      run_cmd(1'b0, list, imm, jreg, spam, cyc, nd, jv, ja);
      chk(log_n == n, "R5", "push access count", 32'(log_n), 32'(n));
      for (int i = 0; i < 12; i++) begin
         if (list[i] && k < log_n) begin
            s = s - 4;
            chk(log_addr[k] == s && log_we[k], "R2", "push address order", log_addr[k], s);
            chk(log_data[k] == rf[20 + i], "R9", "push data from r(20+i)", log_data[k], rf[20 + i]);
            k++;
         end
      end
      s = s - 32'(imm) * 4;
      exp_sp = s;
      chk(sp_out == s, "R3", "push final sp", sp_out, s);
      chk(cyc == n * (lat + 1) + 2, "R5", "push done cycle", 32'(cyc), 32'(n * (lat + 1) + 2));
      chk(nd == 1, "R7", "push done pulses", 32'(nd), 1);
      chk(!jv, "R8", "no jump on push", 32'(jv), 0);
   endtask

   task automatic pop_check(input logic [11:0] list, input logic [4:0] imm,
                            input logic [4:0] jreg, output logic jv, output logic [31:0] ja);
      int cyc, nd, k, n;
      logic [31:0] s;
      logic [31:0] expv [0:11];
      n = $countones(list);
      s = exp_sp + 32'(imm) * 4; k = 0;
      for (int i = 11; i >= 0; i--) begin
         expv[i] = list[i] ? mem[s[9:2]] : rf[20 + i];
         if (list[i]) s = s + 4;
      end
      s = exp_sp + 32'(imm) * 4;
      run_cmd(1'b1, list, imm, jreg, 0, cyc, nd, jv, ja);
      chk(log_n == n, "R5", "pop access count", 32'(log_n), 32'(n));
      for (int i = 11; i >= 0; i--) begin
         if (list[i] && k < log_n) begin
            chk(log_addr[k] == s && !log_we[k], "R4", "pop address order", log_addr[k], s);
            s = s + 4; k++;
         end
         chk(rf[20 + i] == expv[i], "R4", "pop register value", rf[20 + i], expv[i]);
      end
      exp_sp = s;
      chk(sp_out == s, "R4", "pop final sp", sp_out, s);
      chk(cyc == n * (lat + 1) + 2, "R5", "pop done cycle", 32'(cyc), 32'(n * (lat + 1) + 2));
      chk(nd == 1, "R7", "pop done pulses", 32'(nd), 1);
   endtask

   task automatic t_push_pop_basic();
      logic jv; logic [31:0] ja;
      lat = 0;
      push_check(12'h825, 5'd3, 5'd5, 0);
      for (int i = 20; i < 32; i++) rf[i] = 32'h0;
      pop_check(12'h825, 5'd3, 5'd0, jv, ja);
      chk(rf[21] == 0, "R5", "unselected r21 untouched", rf[21], 0);
      chk(!jv, "R8", "no jump when jreg zero", 32'(jv), 0);
   endtask

   task automatic t_jump();
      logic jv; logic [31:0] ja, want;
      lat = 1;
      push_check(12'h00F, 5'd0, 5'd0, 0);
      want = rf[22];
      rf[22] = 32'hDEAD_0000;
      pop_check(12'h00F, 5'd0, 5'd22, jv, ja);
      chk(jv, "R8", "jump valid on pop", 32'(jv), 1);
      chk(ja == want, "R8", "jump address after reload", ja, want);
   endtask

   task automatic t_empty();
      logic jv; logic [31:0] ja;
      lat = 0;
      push_check(12'h000, 5'd5, 5'd0, 0);
      pop_check(12'h000, 5'd5, 5'd0, jv, ja);
      chk(exp_sp == SPR, "R4", "empty pop restores sp", exp_sp, SPR);
   endtask

   task automatic t_busy_ignore();
      lat = 2;
      push_check(12'h003, 5'd1, 5'd0, 3);
      chk(!busy, "R7", "idle after ignored command", 32'(busy), 0);
   endtask

   task automatic t_full_slow();
      logic jv; logic [31:0] ja;
      lat = 3; hold_err = 0;
      for (int i = 20; i < 32; i++) rf[i] = 32'h5500_0000 + 32'(i);
      push_check(12'hFFF, 5'd31, 5'd0, 0);
      chk(hold_err == 0, "R6", "request held until ack", 32'(hold_err), 0);
      for (int i = 20; i < 32; i++) rf[i] = 32'hFFFF_FFFF;
      pop_check(12'hFFF, 5'd31, 5'd0, jv, ja);
      chk(rf[31] == 32'h5500_001F, "R9", "r31 restored", rf[31], 32'h5500_001F);
      chk(stray_jv == 0, "R8", "jump only with done", 32'(stray_jv), 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'h1000_0000 + 32'(i);
      for (int i = 0; i < 32; i++)  rf[i]  = 32'hA000_0000 + 32'(i);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_push_pop_basic();
      t_jump();
      t_empty();
      t_busy_ignore();
      t_full_slow();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule